// File: doc/BRIEF.md
# UART Receive Buffer Status Controller

This block sits between the receive shifter of a serial port and the data register that the processor reads. Each time the shifter reports a finished frame, the block decides whether to copy the frame into the data register or to record an overrun. A frame is copied only when the previous one has already been collected. The block holds five status flags: data ready, overrun, noise, framing error and parity error. It drives a receive interrupt. The flags are cleared by a two-step handshake on the register bus: a status read followed by a data read.

The three error flags describe only a frame that was actually copied. They change in the same cycle as the data ready flag. An overrun leaves the buffered frame and its error flags as they were, and the new frame is lost. The status read takes a snapshot of the flags and arms the clear. The following data read then clears only the flags in that snapshot, so an event that arrives between the two reads is not lost.

Top module: `uart_rx_status_ctrl`

## Requirements
- R1: A frame-complete strobe while data ready is clear (after any same-cycle clear) loads `frameData` into the data register and sets data ready (status bit 0) at the next clock edge.
- R2: On a load, noise (bit 2), framing (bit 3) and parity (bit 4) take the values of the frame's own indications in the same cycle that data ready sets.
- R3: A frame-complete strobe while data ready is set sets overrun (bit 1) and leaves the data register and the three error flags unchanged. Every frame therefore sets either data ready or overrun.
- R4: `rxIrq` is high exactly when `rxIntEn` is high and data ready is set.
- R5: A status read arms the clear and snapshots the flags. The next data read clears every flag that was set in that snapshot and disarms the clear.
- R6: A flag that sets between the arming status read and the clearing data read stays set after the clear.
- R7: A data read with the clear not armed changes no flag. A status read, including one in the same cycle as a data read, re-arms the clear with a fresh snapshot and clears nothing.
- R8: When a clearing data read and a frame-complete strobe coincide, the clear is applied first, and the frame is then handled as a normal load.
- R9: With `nineBit` low, bit 8 of `dataOut` reads as zero. With `nineBit` high, all nine bits are returned.
- R10: After reset all flags are zero, the data register is zero, the clear is not armed and `rxIrq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameDone | input | 1 | One-cycle strobe: the shifter holds a finished frame |
| frameData | input | 9 | Received frame bits |
| frameNoise | input | 1 | Noise seen on the finished frame |
| frameFramingErr | input | 1 | Bad stop bit on the finished frame |
| frameParityErr | input | 1 | Parity mismatch on the finished frame |
| nineBit | input | 1 | 1 = 9-bit frames, 0 = 8-bit frames |
| rxIntEn | input | 1 | Receive interrupt enable |
| rdStatus | input | 1 | Bus read strobe of the status register |
| rdData | input | 1 | Bus read strobe of the data register |
| statusOut | output | 5 | Flags {parity, framing, noise, overrun, ready} |
| dataOut | output | 9 | Receive data register contents |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
The clear is armed only after a status read, so a stale snapshot or a wrong arm bit shows at the ports in the cycle after the next data read. The symptom is a flag that should have survived but is gone, or a flag that should have cleared but is still set. A wrong decision between load and overrun shows one cycle after the frame strobe: `dataOut` is overwritten, or a set error flag changes. Each table step compares both the status and the data register after every edge, so such faults appear at the first step that depends on them.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;
  localparam int DATA_W = 9;
  localparam int FLAG_W = 5;
  localparam int F_READY = 0;
  localparam int F_OVR   = 1;
  localparam int F_NOISE = 2;
  localparam int F_FRAME = 3;
  localparam int F_PAR   = 4;

  typedef struct packed {
    logic              load;
    logic              setOvr;
    logic [FLAG_W-1:0] clrMask;
  } rxStrobe_t;
endpackage

// File: rtl/uart_rx_status_ctrl_fsm.sv
module uart_rx_status_ctrl_fsm
  import uart_rx_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameDone,
  input  logic              rdStatus,
  input  logic              rdData,
  input  logic [FLAG_W-1:0] flags,
  output rxStrobe_t         strobe
);
  logic              armed;
  logic [FLAG_W-1:0] snap;
  logic              doClear;
  logic              readyAfterClr;

  assign doClear       = rdData && armed && !rdStatus;
  assign readyAfterClr = flags[F_READY] && !(doClear && snap[F_READY]);

  always_comb begin
    strobe.clrMask = doClear ? snap : '0;
    strobe.load    = frameDone && !readyAfterClr;
    strobe.setOvr  = frameDone && readyAfterClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      snap  <= '0;
    end else if (rdStatus) begin
      armed <= 1'b1;
      snap  <= flags;
    end else if (rdData) begin
      armed <= 1'b0;
    end
  end

  // R5
  clr_needs_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrMask != '0) |-> (armed && $past(rdStatus || armed)));
endmodule

// File: rtl/uart_rx_status_datapath.sv
module uart_rx_status_datapath
  import uart_rx_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic [DATA_W-1:0] frameData,
  input  logic              frameNoise,
  input  logic              frameFramingErr,
  input  logic              frameParityErr,
  output logic [FLAG_W-1:0] flags,
  output logic [DATA_W-1:0] dataReg
);
  logic [FLAG_W-1:0] flagsNext;

  always_comb begin
    flagsNext = flags & ~strobe.clrMask;
    if (strobe.load) begin
      flagsNext[F_READY] = 1'b1;
      flagsNext[F_NOISE] = frameNoise;
      flagsNext[F_FRAME] = frameFramingErr;
      flagsNext[F_PAR]   = frameParityErr;
    end
    if (strobe.setOvr) flagsNext[F_OVR] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags   <= '0;
      dataReg <= '0;
    end else begin
      flags <= flagsNext;
      if (strobe.load) dataReg <= frameData;
    end
  end

  // R1
  load_fills_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (flags[F_READY] && dataReg == $past(frameData)));

  // R3
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setOvr |=> ($stable(dataReg) && flags[F_OVR]));

  // R3
  ovr_keeps_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setOvr |=> (flags[F_PAR:F_NOISE] ==
                       ($past(flags[F_PAR:F_NOISE]) & ~$past(strobe.clrMask[F_PAR:F_NOISE]))));
endmodule

// File: rtl/uart_rx_status_ctrl.sv
module uart_rx_status_ctrl
  import uart_rx_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameDone,
  input  logic [DATA_W-1:0] frameData,
  input  logic              frameNoise,
  input  logic              frameFramingErr,
  input  logic              frameParityErr,
  input  logic              nineBit,
  input  logic              rxIntEn,
  input  logic              rdStatus,
  input  logic              rdData,
  output logic [FLAG_W-1:0] statusOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              rxIrq
);
  rxStrobe_t         strobe;
  logic [FLAG_W-1:0] flags;
  logic [DATA_W-1:0] dataReg;

  uart_rx_status_ctrl_fsm u_fsm (
    .clk(clk), .rstN(rstN), .frameDone(frameDone),
    .rdStatus(rdStatus), .rdData(rdData), .flags(flags), .strobe(strobe)
  );

  uart_rx_status_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .frameData(frameData),
    .frameNoise(frameNoise), .frameFramingErr(frameFramingErr),
    .frameParityErr(frameParityErr), .flags(flags), .dataReg(dataReg)
  );

  assign statusOut = flags;
  assign dataOut   = nineBit ? dataReg : {1'b0, dataReg[DATA_W-2:0]};
  assign rxIrq     = rxIntEn && flags[F_READY];

  // R1 R3
  frame_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> (statusOut[F_READY] || statusOut[F_OVR]));
endmodule

// File: tb/uart_rx_status_ctrl_tb.sv
module uart_rx_status_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameDone = 0, frameNoise = 0, frameFramingErr = 0, frameParityErr = 0;
  logic [8:0] frameData = '0;
  logic       nineBit = 1'b1, rxIntEn = 1'b1, rdStatus = 0, rdData = 0;
  logic [4:0] statusOut;
  logic [8:0] dataOut;
  logic       rxIrq;
  int         nChecks = 0, nFails = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  uart_rx_status_ctrl u_dut (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .frameData(frameData),
    .frameNoise(frameNoise), .frameFramingErr(frameFramingErr),
    .frameParityErr(frameParityErr), .nineBit(nineBit), .rxIntEn(rxIntEn),
    .rdStatus(rdStatus), .rdData(rdData), .statusOut(statusOut),
    .dataOut(dataOut), .rxIrq(rxIrq)
  );

  // {frameDone, data[8:0], noise, framing, parity, rdS, rdD, expStatus[4:0], expData[8:0]}
  localparam int NV = 13;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 9'h1A5, 3'b100, 2'b00, 5'd5,  9'h1A5}, // R1 R2 load with noise
    {1'b1, 9'h055, 3'b000, 2'b00, 5'd7,  9'h1A5}, // R3 overrun
    {1'b0, 9'h000, 3'b000, 2'b10, 5'd7,  9'h1A5}, // R5 arm
    {1'b0, 9'h000, 3'b000, 2'b01, 5'd0,  9'h1A5}, // R5 clear
    {1'b1, 9'h0F0, 3'b011, 2'b00, 5'd25, 9'h0F0}, // R2 framing+parity
    {1'b0, 9'h000, 3'b000, 2'b01, 5'd25, 9'h0F0}, // R7 unarmed data read
    {1'b0, 9'h000, 3'b000, 2'b10, 5'd25, 9'h0F0}, // R5 arm
    {1'b1, 9'h033, 3'b111, 2'b00, 5'd27, 9'h0F0}, // R3 overrun between reads
    {1'b0, 9'h000, 3'b000, 2'b01, 5'd2,  9'h0F0}, // R6 overrun survives
    {1'b0, 9'h000, 3'b000, 2'b10, 5'd2,  9'h0F0}, // R5 arm on overrun
    {1'b1, 9'h111, 3'b000, 2'b01, 5'd1,  9'h111}, // R8 clear then load
    {1'b0, 9'h000, 3'b000, 2'b11, 5'd1,  9'h111}, // R7 both strobes rearm only
    {1'b0, 9'h000, 3'b000, 2'b01, 5'd0,  9'h111}  // R5 clear after rearm
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic fd, input logic [8:0] d, input logic [2:0] e,
                      input logic rs, input logic rd);
    @(negedge clk);
    frameDone = fd; frameData = d;
    {frameNoise, frameFramingErr, frameParityErr} = e;
    rdStatus = rs; rdData = rd;
    @(posedge clk); #1;
    frameDone = 0; rdStatus = 0; rdData = 0;
    {frameNoise, frameFramingErr, frameParityErr} = 3'b000;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 status", 32'(statusOut), 0);
    check("R10 data", 32'(dataOut), 0);
    check("R10 irq", 32'(rxIrq), 0);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][28], VEC[i][27:19], VEC[i][18:16], VEC[i][15], VEC[i][14]);
      check($sformatf("R1-table step %0d status", i), 32'(statusOut), 32'(VEC[i][13:9]));
      check($sformatf("R3-table step %0d data", i), 32'(dataOut), 32'(VEC[i][8:0]));
    end
    // R4 interrupt follows ready and enable
    check("R4 idle", 32'(rxIrq), 0);
    step(1'b1, 9'h1C3, 3'b000, 1'b0, 1'b0);
    check("R4 ready", 32'(rxIrq), 1);
    rxIntEn = 1'b0; #1;
    check("R4 disabled", 32'(rxIrq), 0);
    rxIntEn = 1'b1; #1;
    // R9 8-bit mode hides bit 8
    nineBit = 1'b0; #1;
    check("R9 eight-bit", 32'(dataOut), 32'h0C3);
    nineBit = 1'b1; #1;
    check("R9 nine-bit", 32'(dataOut), 32'h1C3);
    // R10 reset mid-run clears everything and disarms
    step(1'b0, 9'h0, 3'b000, 1'b1, 1'b0);
    rstN = 1'b0; #1;
    check("R10 reset status", 32'(statusOut), 0);
    rstN = 1'b1;
    step(1'b1, 9'h07E, 3'b000, 1'b0, 1'b0);
    step(1'b0, 9'h0, 3'b000, 1'b0, 1'b1);
    check("R10 disarmed after reset", 32'(statusOut), 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule